// File: doc/BRIEF.md
# SPI Slave Byte Shifter

This block is the receive and transmit shifter of an SPI slave that moves one byte at a time. Three inputs come from the bus: the serial clock, the master's data line and the active-low select. Each passes through a two-flop synchronizer into the system clock. Clock edges are then found by comparing the synchronized clock with its previous value. The block drives the slave data output together with an output enable.

Three static inputs set the bus format:
- `cpol` gives the idle level of the serial clock.
- `cpha` says whether data is captured on the leading edge or on the trailing edge.
- `lsb_first` sets the bit order, which is the same for both directions.

The local side writes the next byte to send into a single holding register with a one-cycle load strobe. Each completed received byte is presented with a one-cycle valid pulse.

The system clock must run at least four times faster than the serial clock. The mode inputs may change only while the select is high.

Top module: `spi_slave_shifter`

## Requirements
- R1: After reset, `miso_oe` is 0, `rx_valid` is 0 and `rx_data` is 0x00.
- R2: `miso_oe` is 1 exactly while the synchronized select is low: it follows `ss_n_in` inverted, two system clocks later.
- R3: With `cpha`=0, the first data bit is on `miso_out` before the first serial clock edge after select falls. The block captures `mosi_in` on each leading edge and moves `miso_out` to the next bit on each trailing edge.
- R4: With `cpha`=1, the first data bit appears on `miso_out` only after the first (leading) serial clock edge. The block captures `mosi_in` on each trailing edge.
- R5: The leading edge is the clock's move away from its idle level `cpol`: rising for `cpol`=0 and falling for `cpol`=1. Both idle levels work for both `cpha` values.
- R6: With `lsb_first`=0, bit 7 is sent and received first. With `lsb_first`=1, bit 0 is first. The same order applies to `miso_out` and to `rx_data`.
- R7: After every eighth capture edge, `rx_valid` is 1 for exactly one system clock. In that cycle `rx_data` holds the received byte, and `rx_data` keeps this value until the next pulse.
- R8: With `cpha`=1, several bytes can pass while select stays low. The bit count restarts after each eighth capture edge, and every byte produces its own `rx_valid` pulse.
- R9: Raising select discards a partial byte: no `rx_valid` is produced, and the next selected byte starts again at its first bit.
- R10: A byte written with `tx_load` is sent in the next byte that starts. A byte that starts with no byte loaded since the previous start sends 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpol | input | 1 | Idle level of the serial clock |
| cpha | input | 1 | 0: capture on leading edge; 1: capture on trailing edge |
| lsb_first | input | 1 | 1: bit 0 first; 0: bit 7 first |
| sck_in | input | 1 | Serial clock from the master |
| mosi_in | input | 1 | Serial data from the master |
| ss_n_in | input | 1 | Active-low slave select |
| miso_out | output | 1 | Serial data to the master, meaningful while `miso_oe` is 1 |
| miso_oe | output | 1 | Output enable for `miso_out` |
| tx_data | input | DW | Byte to send next |
| tx_load | input | 1 | One-cycle strobe that writes `tx_data` into the holding register |
| rx_data | output | DW | Last completed received byte |
| rx_valid | output | 1 | One-cycle pulse when `rx_data` is updated |

## Verification
A bit counter that is off by one shows up at the byte boundary. The byte it completes is shifted by one place in `rx_data`, and the master captures a shifted or zero byte on `miso_out`, both within the same byte time. A wrong edge choice for a `cpol`/`cpha` pair corrupts the first bit of the first byte in that mode. A holding register whose full flag is not cleared keeps resending the old byte where 0x00 is expected, on the very next byte. A stale count after select rises appears either as an extra `rx_valid` or as a misaligned byte on the next selection.

// File: rtl/spi_slave_shifter.sv
module spi_slave_shifter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpol,
  input  logic          cpha,
  input  logic          lsb_first,
  input  logic          sck_in,
  input  logic          mosi_in,
  input  logic          ss_n_in,
  output logic          miso_out,
  output logic          miso_oe,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_load,
  output logic [DW-1:0] rx_data,
  output logic          rx_valid
);
  localparam int CW = $clog2(DW);

  logic [1:0] sck_r, mosi_r, ss_r;
  logic sck_d, ss_d;
  logic [DW-1:0] tx_sh, rx_sh, hold;
  logic hold_full, need_load;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_r  <= '0;
      mosi_r <= '0;
      ss_r   <= '1;
      sck_d  <= 1'b0;
      ss_d   <= 1'b1;
    end else begin
      sck_r  <= {sck_r[0], sck_in};
      mosi_r <= {mosi_r[0], mosi_in};
      ss_r   <= {ss_r[0], ss_n_in};
      sck_d  <= sck_r[1];
      ss_d   <= ss_r[1];
    end
  end

  wire sel     = ~ss_r[1];
  wire ss_fall = ss_d & sel;
  wire lead    = sel && (sck_d == cpol) && (sck_r[1] != cpol);
  wire trail   = sel && (sck_d != cpol) && (sck_r[1] == cpol);
  wire sample  = cpha ? trail : lead;
  wire shift   = cpha ? lead : trail;
  wire last    = (cnt == CW'(DW-1));

  wire [DW-1:0] next_tx = hold_full ? hold : '0;
  wire [DW-1:0] rx_next = lsb_first ? {mosi_r[1], rx_sh[DW-1:1]}
                                    : {rx_sh[DW-2:0], mosi_r[1]};

  assign miso_oe  = sel;
  assign miso_out = lsb_first ? tx_sh[0] : tx_sh[DW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh     <= '0;
      rx_sh     <= '0;
      hold      <= '0;
      hold_full <= 1'b0;
      need_load <= 1'b0;
      cnt       <= '0;
      rx_data   <= '0;
      rx_valid  <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (!sel) begin
        cnt       <= '0;
        need_load <= 1'b0;
      end else if (ss_fall) begin
        cnt <= '0;
        if (cpha) need_load <= 1'b1;
        else begin
          tx_sh     <= next_tx;
          hold_full <= 1'b0;
        end
      end else begin
        if (shift) begin
          if (need_load) begin
            tx_sh     <= next_tx;
            hold_full <= 1'b0;
            need_load <= 1'b0;
          end else begin
            tx_sh <= lsb_first ? (tx_sh >> 1) : (tx_sh << 1);
          end
        end
        if (sample) begin
          rx_sh <= rx_next;
          cnt   <= last ? '0 : cnt + CW'(1);
          if (last) begin
            rx_data  <= rx_next;
            rx_valid <= 1'b1;
            if (cpha) need_load <= 1'b1;
          end
        end
      end
      if (tx_load) begin
        hold      <= tx_data;
        hold_full <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_slave_shifter_chk.sv
module spi_slave_shifter_chk #(
  parameter int DW = 8,
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ss_n_in,
  input logic          miso_oe,
  input logic          rx_valid,
  input logic [DW-1:0] rx_data,
  input logic [CW-1:0] cnt
);
  logic [1:0] age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R7
  rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R7
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> $stable(rx_data));

  // R2
  oe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3) |-> (miso_oe == !$past(ss_n_in, 2)));

  // R9
  no_rx_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && rx_valid) |-> !$past(ss_n_in, 3));

  // R9
  idle_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!miso_oe) |-> (cnt == '0));
endmodule

bind spi_slave_shifter spi_slave_shifter_chk #(.DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ss_n_in(ss_n_in), .miso_oe(miso_oe),
  .rx_valid(rx_valid), .rx_data(rx_data), .cnt(cnt)
);

// File: tb/sim_spi_slave_shifter.sv
module sim_spi_slave_shifter;
  localparam int CLK_NS = 10;
  localparam int H = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpol = 1'b0, cpha = 1'b0, lsb = 1'b0;
  logic sck = 1'b0, mosi = 1'b0, ss_n = 1'b1;
  logic [7:0] tx_data = '0;
  logic tx_load = 1'b0;
  logic miso, miso_oe, rx_valid;
  logic [7:0] rx_data;

  int nchk = 0, nerr = 0, vcnt = 0;
  logic [7:0] vlast = '0;

  always #(CLK_NS/2) clk = ~clk;

  spi_slave_shifter #(.DW(8)) u0 (
    .clk(clk), .rst_n(rst_n), .cpol(cpol), .cpha(cpha), .lsb_first(lsb),
    .sck_in(sck), .mosi_in(mosi), .ss_n_in(ss_n), .miso_out(miso),
    .miso_oe(miso_oe), .tx_data(tx_data), .tx_load(tx_load),
    .rx_data(rx_data), .rx_valid(rx_valid)
  );

  always @(negedge clk) if (rst_n && rx_valid) begin
    vcnt++;
    vlast = rx_data;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_mode(input logic p, input logic h, input logic l);
    @(negedge clk);
    cpol = p; sck = p; cpha = h; lsb = l;
    waitn(H);
  endtask

  task automatic load(input logic [7:0] b);
    @(negedge clk);
    tx_data = b; tx_load = 1'b1;
    @(negedge clk);
    tx_load = 1'b0;
  endtask

  function automatic logic bit_at(input logic [7:0] b, input int i, input logic l);
    return l ? b[i] : b[7-i];
  endfunction

  task automatic xbyte(input logic [7:0] mo, input int nbits, output logic [7:0] got);
    got = '0;
    if (!cpha) mosi = bit_at(mo, 0, lsb);
    for (int i = 0; i < nbits; i++) begin
      if (!cpha) begin
        waitn(H);
        got[lsb ? i : 7-i] = miso;
        sck = ~cpol;
        waitn(H);
        sck = cpol;
        if (i < 7) mosi = bit_at(mo, i+1, lsb);
      end else begin
        waitn(H);
        sck = ~cpol;
        mosi = bit_at(mo, i, lsb);
        waitn(H);
        got[lsb ? i : 7-i] = miso;
        sck = cpol;
      end
    end
    waitn(H);
  endtask

  task automatic frame(input logic [7:0] mo, input bit do_ld, input logic [7:0] ld, input string req);
    logic [7:0] got;
    logic [7:0] exp_tx;
    int v0;
    exp_tx = do_ld ? ld : 8'h00;
    if (do_ld) load(ld);
    v0 = vcnt;
    @(negedge clk); ss_n = 1'b0;
    waitn(3);
    check(miso_oe === 1'b1, {req, " R2 oe on"}, miso_oe, 1);
    xbyte(mo, 8, got);
    check(got === exp_tx, {req, " R10 miso byte"}, got, exp_tx);
    check(vcnt == v0 + 1, {req, " R7 one pulse"}, vcnt - v0, 1);
    check(vlast === mo, {req, " R6 rx byte"}, vlast, mo);
    @(negedge clk); ss_n = 1'b1;
    waitn(3);
    check(miso_oe === 1'b0, {req, " R2 oe off"}, miso_oe, 0);
    waitn(H);
  endtask

  initial begin
    logic [7:0] got, a, b;
    int v0;
    void'($urandom(32'h1234_5eed));
    waitn(4);
    rst_n = 1'b1;
    waitn(2);
    // R1
    check(miso_oe === 1'b0, "R1 oe", miso_oe, 0);
    check(rx_valid === 1'b0, "R1 valid", rx_valid, 0);
    check(rx_data === 8'h00, "R1 rx_data", rx_data, 0);

    // R3 R5 R6: all four clock formats, both orders
    for (int m = 0; m < 8; m++) begin
      set_mode(m[0], m[1], m[2]);
      frame(8'hA1 ^ 8'(m), 1'b1, 8'h3C ^ 8'(m << 4), m[1] ? "R4 R5" : "R3 R5");
    end

    // R10: no load since last start -> zero
    set_mode(1'b0, 1'b0, 1'b0);
    frame(8'h5A, 1'b0, 8'h00, "R10 empty");
    set_mode(1'b1, 1'b1, 1'b1);
    frame(8'hC3, 1'b0, 8'h00, "R10 empty cpha1");

    // R9: partial byte discarded
    for (int h = 0; h < 2; h++) begin
      set_mode(1'b0, h[0], 1'b0);
      load(8'hFF);
      v0 = vcnt;
      @(negedge clk); ss_n = 1'b0;
      xbyte(8'hF0, 4, got);
      @(negedge clk); ss_n = 1'b1;
      waitn(H);
      check(vcnt == v0, "R9 no pulse on partial", vcnt - v0, 0);
      frame(8'h96, 1'b1, 8'h69, "R9 restart");
    end

    // R8: back-to-back bytes with cpha=1
    for (int l = 0; l < 2; l++) begin
      set_mode(l[0], 1'b1, l[0]);
      @(negedge clk); ss_n = 1'b0;
      for (int k = 0; k < 4; k++) begin
        a = 8'($urandom);
        b = 8'($urandom);
        if (k != 2) load(b);
        v0 = vcnt;
        xbyte(a, 8, got);
        check(vcnt == v0 + 1, "R8 pulse per byte", vcnt - v0, 1);
        check(vlast === a, "R8 rx byte", vlast, a);
        check(got === (k != 2 ? b : 8'h00), "R8 R10 tx byte", got, (k != 2 ? b : 8'h00));
      end
      @(negedge clk); ss_n = 1'b1;
      waitn(H);
    end

    // random mix
    for (int r = 0; r < 30; r++) begin
      set_mode(1'($urandom), 1'($urandom), 1'($urandom));
      frame(8'($urandom), ($urandom % 4) != 0, 8'($urandom), "R6 random");
    end

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog actual timeout expected done");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule